// File: doc/BRIEF.md
# FIFO-Buffered Configuration Port Controller

This block is a memory-mapped peripheral that carries 32-bit configuration words between a host bus and a configuration port. Words the host writes go into a 1024-entry transmit queue. A start-write command drains that queue into the port over a valid/ready handshake. A start-readback command pulls a programmed number of words from the port into a 256-entry receive queue. The host then reads them out one at a time through a data window.

The host never waits on a handshake. It paces itself from two live counters: the number of free transmit slots and the number of words ready to read. A status word shows whether a transfer is running, together with four flags passed through from the port. Two held control bits flush both queues or reset the whole block. The host sets such a bit and then clears it again.

Register map (byte offsets):

| Offset | Access | Use |
|---|---|---|
| 0x100 | write | transmit data |
| 0x104 | read | receive data |
| 0x108 | read/write | readback size |
| 0x10C | read/write | control |
| 0x110 | read | status |
| 0x114 | read | transmit vacancy |
| 0x118 | read | receive occupancy |

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset, status reads 0x1F (with portFlags 0 and portBusy 0), vacancy reads 1024, occupancy reads 0 and control reads 0.
- R2: Each write to offset 0x100 stores one word and lowers the vacancy by one. A write while the vacancy is 0 is dropped: the word is never sent to the port and the vacancy stays at 0.
- R3: Writing control bit 0 (value 0x1) while idle sends the stored words to the port in write order. A word moves when portWrValid and portWrReady are both high. portWrValid and portWrData hold steady while the port stalls. Status bit 0 reads 0 until the queue is empty and the port has taken the last word, then reads 1.
- R4: The size register at 0x108 keeps only its low 12 bits (0xFFFFF reads back as 0xFFF). Writing control bit 1 (value 0x2) while idle takes exactly that many words from the port into the receive queue. The host reads them back in order at 0x104, and each read lowers the occupancy by one.
- R5: During a readback, portRdReady is low while the receive queue holds 256 words. It rises again once the host frees space, and the total number of words taken still equals the programmed size.
- R6: A read of 0x104 while the receive queue is empty returns 0 and leaves the occupancy unchanged.
- R7: A start-readback with a size of 0 takes no word from the port, and status bit 0 stays 1.
- R8: A start command written while a transfer is active is ignored. The start bits always read back as 0.
- R9: While control bit 2 (value 0x4) is set, both queues are empty: vacancy reads 1024 and occupancy reads 0.
- R10: While control bit 3 (value 0x8) is set, the block is held in its reset state: any transfer is abandoned (status bit 0 reads 1), the size register reads 0, and both queues are flushed.
- R11: Status bits 1 to 4 always read 1. Status bits 5 to 8 mirror portFlags bits 0 to 3 (abort-low, read-in-progress, aligned, configuration error).
- R12: Status bit 0 reads 0 whenever portBusy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 9 | Byte address of the register access |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdEn | input | 1 | Register read strobe (pops the receive queue at 0x104) |
| busRdData | output | 32 | Register read data, combinational from busAddr |
| portWrValid | output | 1 | Word offered to the configuration port |
| portWrReady | input | 1 | Port accepts the offered word |
| portWrData | output | 32 | Word offered to the port |
| portRdValid | input | 1 | Port offers a readback word |
| portRdReady | output | 1 | Block accepts the readback word |
| portRdData | input | 32 | Readback word from the port |
| portBusy | input | 1 | Port is still processing |
| portFlags | input | 4 | Port condition flags shown in status |

## Verification
The hardest state to reach is a readback stalled on a full receive queue, because it needs a size larger than the queue depth and a host that is not reading. The bench requests 300 words from a port that is always ready to send. It waits until occupancy reaches 256 and confirms that no further word moves. It then drains part of the queue and checks that the remaining words arrive in order and that the total count is exact. Overflowing the transmit queue likewise takes a full 1024-word fill followed by extra writes, and a scoreboard confirms that the extra words never reach the port.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  localparam int OFF_WDATA = 'h100;
  localparam int OFF_RDATA = 'h104;
  localparam int OFF_SIZE  = 'h108;
  localparam int OFF_CTRL  = 'h10C;
  localparam int OFF_STAT  = 'h110;
  localparam int OFF_VAC   = 'h114;
  localparam int OFF_OCC   = 'h118;

  // control word bit positions
  localparam int CB_START_WR = 0;
  localparam int CB_START_RD = 1;
  localparam int CB_FLUSH    = 2;
  localparam int CB_SOFT_RST = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } xferState_t;

  typedef struct packed {
    logic wfPush;
    logic wfPop;
    logic rfPush;
    logic rfPop;
    logic flush;
  } dpStrobes_t;

endpackage

// File: rtl/cfgport_fifo.sv
module cfgport_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wData,
  output logic [WIDTH-1:0] rData,
  output logic [CW-1:0]    count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  assign doPop  = pop && (count != '0);
  assign doPush = push && (count != CW'(DEPTH));
  assign rData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/cfgport_datapath.sv
module cfgport_datapath
  import cfgport_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 9,
  parameter int SIZE_W   = 12,
  parameter int FLAG_W   = 4,
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  localparam int WCW = $clog2(WR_DEPTH) + 1,
  localparam int RCW = $clog2(RD_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] portRdData,
  output logic [DATA_W-1:0] portWrData,
  input  logic [SIZE_W-1:0] sizeReg,
  input  logic              ctrlFlush,
  input  logic              ctrlSoftRst,
  input  logic              done,
  input  logic [FLAG_W-1:0] portFlags,
  output logic              wfEmpty,
  output logic              rfFull,
  output logic [WCW-1:0]    wfCount,
  output logic [RCW-1:0]    rfCount
);

  logic [DATA_W-1:0] rfHead;

  cfgport_fifo #(.WIDTH(DATA_W), .DEPTH(WR_DEPTH)) i_wrFifo (
    .clk   (clk),
    .rstN  (rstN),
    .flush (strobes.flush),
    .push  (strobes.wfPush),
    .pop   (strobes.wfPop),
    .wData (busWrData),
    .rData (portWrData),
    .count (wfCount)
  );

  cfgport_fifo #(.WIDTH(DATA_W), .DEPTH(RD_DEPTH)) i_rdFifo (
    .clk   (clk),
    .rstN  (rstN),
    .flush (strobes.flush),
    .push  (strobes.rfPush),
    .pop   (strobes.rfPop),
    .wData (portRdData),
    .rData (rfHead),
    .count (rfCount)
  );

  assign wfEmpty = (wfCount == '0);
  assign rfFull  = (rfCount == RCW'(RD_DEPTH));

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      ADDR_W'(OFF_RDATA): busRdData = (rfCount == '0) ? '0 : rfHead;
      ADDR_W'(OFF_SIZE):  busRdData = DATA_W'(sizeReg);
      ADDR_W'(OFF_CTRL):  busRdData = DATA_W'({ctrlSoftRst, ctrlFlush, 2'b00});
      ADDR_W'(OFF_STAT):  busRdData = DATA_W'({portFlags, 4'hF, done});
      ADDR_W'(OFF_VAC):   busRdData = DATA_W'(WR_DEPTH) - DATA_W'(wfCount);
      ADDR_W'(OFF_OCC):   busRdData = DATA_W'(rfCount);
      default:            busRdData = '0;
    endcase
  end

endmodule

// File: rtl/cfgport_control.sv
module cfgport_control
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [SIZE_W-1:0] wData,
  input  logic              wfEmpty,
  input  logic              rfFull,
  input  logic              portWrReady,
  input  logic              portRdValid,
  input  logic              portBusy,
  output logic              portWrValid,
  output logic              portRdReady,
  output dpStrobes_t        strobes,
  output logic [SIZE_W-1:0] sizeReg,
  output logic              ctrlFlush,
  output logic              ctrlSoftRst,
  output logic              done
);

  xferState_t        state;
  logic [SIZE_W-1:0] remain;
  logic              ctrlWr, sizeWr, startWr, startRd, rfPushFire;

  assign ctrlWr  = busWrEn && (busAddr == ADDR_W'(OFF_CTRL));
  assign sizeWr  = busWrEn && (busAddr == ADDR_W'(OFF_SIZE));
  assign startWr = ctrlWr && wData[CB_START_WR];
  assign startRd = ctrlWr && wData[CB_START_RD] && !wData[CB_START_WR];

  assign portWrValid = (state == ST_WRITE) && !wfEmpty;
  assign portRdReady = (state == ST_READ) && !rfFull;
  assign rfPushFire  = portRdReady && portRdValid;
  assign done        = (state == ST_IDLE) && !portBusy;

  always_comb begin
    strobes.wfPush = busWrEn && (busAddr == ADDR_W'(OFF_WDATA));
    strobes.rfPop  = busRdEn && (busAddr == ADDR_W'(OFF_RDATA));
    strobes.wfPop  = portWrValid && portWrReady;
    strobes.rfPush = rfPushFire;
    strobes.flush  = ctrlFlush || ctrlSoftRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      remain      <= '0;
      sizeReg     <= '0;
      ctrlFlush   <= 1'b0;
      ctrlSoftRst <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ctrlFlush   <= wData[CB_FLUSH];
        ctrlSoftRst <= wData[CB_SOFT_RST];
      end
      if (ctrlSoftRst) begin
        state   <= ST_IDLE;
        remain  <= '0;
        sizeReg <= '0;
      end else begin
        if (sizeWr) sizeReg <= wData;
        unique case (state)
          ST_IDLE: begin
            if (startWr) begin
              state <= ST_WRITE;
            end else if (startRd && (sizeReg != '0)) begin
              state  <= ST_READ;
              remain <= sizeReg;
            end
          end
          ST_WRITE: begin
            if (wfEmpty) state <= ST_IDLE;
          end
          ST_READ: begin
            if (rfPushFire) begin
              remain <= remain - 1'b1;
              if (remain == SIZE_W'(1)) state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 9,
  parameter int SIZE_W   = 12,
  parameter int FLAG_W   = 4,
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  localparam int WCW = $clog2(WR_DEPTH) + 1,
  localparam int RCW = $clog2(RD_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              portWrValid,
  input  logic              portWrReady,
  output logic [DATA_W-1:0] portWrData,
  input  logic              portRdValid,
  output logic              portRdReady,
  input  logic [DATA_W-1:0] portRdData,
  input  logic              portBusy,
  input  logic [FLAG_W-1:0] portFlags
);

  dpStrobes_t        strobes;
  logic [SIZE_W-1:0] sizeReg;
  logic              ctrlFlush, ctrlSoftRst, done, wfEmpty, rfFull;
  logic [WCW-1:0]    wfCount;
  logic [RCW-1:0]    rfCount;

  cfgport_control #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_control (
    .clk         (clk),
    .rstN        (rstN),
    .busAddr     (busAddr),
    .busWrEn     (busWrEn),
    .busRdEn     (busRdEn),
    .wData       (busWrData[SIZE_W-1:0]),
    .wfEmpty     (wfEmpty),
    .rfFull      (rfFull),
    .portWrReady (portWrReady),
    .portRdValid (portRdValid),
    .portBusy    (portBusy),
    .portWrValid (portWrValid),
    .portRdReady (portRdReady),
    .strobes     (strobes),
    .sizeReg     (sizeReg),
    .ctrlFlush   (ctrlFlush),
    .ctrlSoftRst (ctrlSoftRst),
    .done        (done)
  );

  cfgport_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .FLAG_W(FLAG_W),
    .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .portRdData  (portRdData),
    .portWrData  (portWrData),
    .sizeReg     (sizeReg),
    .ctrlFlush   (ctrlFlush),
    .ctrlSoftRst (ctrlSoftRst),
    .done        (done),
    .portFlags   (portFlags),
    .wfEmpty     (wfEmpty),
    .rfFull      (rfFull),
    .wfCount     (wfCount),
    .rfCount     (rfCount)
  );

endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
  parameter int DATA_W   = 32,
  parameter int WR_DEPTH = 1024,
  parameter int RD_DEPTH = 256,
  localparam int WCW = $clog2(WR_DEPTH) + 1,
  localparam int RCW = $clog2(RD_DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              portWrValid,
  input logic              portWrReady,
  input logic [DATA_W-1:0] portWrData,
  input logic              portRdReady,
  input logic              portBusy,
  input logic              done,
  input logic              flushNow,
  input logic [WCW-1:0]    wfCount,
  input logic [RCW-1:0]    rfCount
);

  AST_WR_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !portWrValid); // R3

  AST_WR_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN || flushNow)
    (portWrValid && !portWrReady) |=> (portWrValid && $stable(portWrData))); // R3

  AST_RD_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !portRdReady); // R4

  AST_RF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (rfCount == RCW'(RD_DEPTH)) |-> !portRdReady); // R5

  AST_RF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    rfCount <= RCW'(RD_DEPTH)); // R5

  AST_WF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    wfCount <= WCW'(WR_DEPTH)); // R2

  AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    portBusy |-> !done); // R12

endmodule

bind cfgport_ctrl cfgport_checker #(
  .DATA_W(DATA_W), .WR_DEPTH(WR_DEPTH), .RD_DEPTH(RD_DEPTH)
) i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .portWrValid (portWrValid),
  .portWrReady (portWrReady),
  .portWrData  (portWrData),
  .portRdReady (portRdReady),
  .portBusy    (portBusy),
  .done        (done),
  .flushNow    (strobes.flush),
  .wfCount     (wfCount),
  .rfCount     (rfCount)
);

// File: tb/test_cfgport_ctrl.sv
module test_cfgport_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WR_DEPTH   = 1024;
  localparam int RD_DEPTH   = 256;

  localparam logic [8:0] A_WDATA = 9'h100;
  localparam logic [8:0] A_RDATA = 9'h104;
  localparam logic [8:0] A_SIZE  = 9'h108;
  localparam logic [8:0] A_CTRL  = 9'h10C;
  localparam logic [8:0] A_STAT  = 9'h110;
  localparam logic [8:0] A_VAC   = 9'h114;
  localparam logic [8:0] A_OCC   = 9'h118;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        portWrValid;
  logic        portWrReady = 1'b0;
  logic [31:0] portWrData;
  logic        portRdValid = 1'b0;
  logic        portRdReady;
  logic [31:0] portRdData;
  logic        portBusy = 1'b0;
  logic [3:0]  portFlags = '0;

  int nChecks = 0;
  int nErrors = 0;
  logic [31:0] expWr[$];
  logic [31:0] expRd[$];
  logic        wrAuto = 1'b0;
  logic        srcEn = 1'b0;
  logic        pendFire = 1'b0;
  logic [31:0] srcWord = 32'hA000_0000;
  int          nFired = 0;

  assign portRdData = srcWord;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_ctrl i_cfgport_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .portWrValid(portWrValid), .portWrReady(portWrReady), .portWrData(portWrData),
    .portRdValid(portRdValid), .portRdReady(portRdReady), .portRdData(portRdData),
    .portBusy(portBusy), .portFlags(portFlags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // write-side monitor: the port model drives ready, then scores the word
  always @(negedge clk) begin
    portWrReady = wrAuto ? ($urandom_range(2) != 0) : 1'b0;
    if (rstN && portWrValid && portWrReady) begin
      if (expWr.size() == 0) check("R3 unexpected word", portWrData, 32'hx);
      else check("R3 word order", portWrData, expWr.pop_front());
    end
  end

  // readback source: the word offered at one negedge moves at the next posedge
  always @(negedge clk) begin
    if (pendFire) begin
      srcWord = srcWord + 32'h1;
      nFired++;
    end
    portRdValid = srcEn;
    pendFire = rstN && portRdValid && portRdReady;
    if (pendFire) expRd.push_back(srcWord);
  end

  task automatic busWrite(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic pushWord(input logic [31:0] w);
    if (expWr.size() < WR_DEPTH) expWr.push_back(w);
    busWrite(A_WDATA, w);
  endtask

  task automatic waitDone(input string req);
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      busRead(A_STAT, s);
      if (s[0]) return;
    end
    check({req, " done timeout"}, 32'h0, 32'h1);
  endtask

  task automatic drainRead(input int n, input string req);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      busRead(A_RDATA, d);
      if (expRd.size() == 0) check({req, " extra read"}, d, 32'hx);
      else check(req, d, expRd.pop_front());
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++; nErrors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int f0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(A_STAT, d); check("R1 status", d, 32'h1F);
    busRead(A_VAC, d);  check("R1 vacancy", d, 32'd1024);
    busRead(A_OCC, d);  check("R1 occupancy", d, 32'd0);
    busRead(A_CTRL, d); check("R1 control", d, 32'd0);

    // R2 push, R3 drain with stalls, R8 start ignored while active
    for (int i = 0; i < 5; i++) pushWord(32'h1000_0000 + i);
    busRead(A_VAC, d); check("R2 vacancy after 5", d, 32'd1019);
    busWrite(A_SIZE, 32'd4);
    busWrite(A_CTRL, 32'h1);
    busRead(A_STAT, d); check("R3 done low while active", d & 32'h1, 32'h0);
    busRead(A_CTRL, d); check("R8 start bits read 0", d, 32'h0);
    srcEn = 1'b1;
    f0 = nFired;
    busWrite(A_CTRL, 32'h2);
    repeat (4) @(negedge clk);
    wrAuto = 1'b1;
    waitDone("R3");
    repeat (3) @(negedge clk);
    check("R8 readback start ignored", nFired - f0, 0);
    busRead(A_OCC, d); check("R8 occupancy untouched", d, 32'd0);
    check("R3 all words sent", expWr.size(), 0);
    busRead(A_VAC, d); check("R3 vacancy restored", d, 32'd1024);
    srcEn = 1'b0;
    wrAuto = 1'b0;

    // R2 overflow: fill then write extras
    for (int i = 0; i < WR_DEPTH + 3; i++) pushWord(32'h2000_0000 + i);
    busRead(A_VAC, d); check("R2 vacancy full", d, 32'd0);
    wrAuto = 1'b1;
    busWrite(A_CTRL, 32'h1);
    waitDone("R2");
    repeat (3) @(negedge clk);
    check("R2 dropped words not sent", expWr.size(), 0);
    wrAuto = 1'b0;

    // R4 readback of 10 words, size register width
    busWrite(A_SIZE, 32'hFFFFF);
    busRead(A_SIZE, d); check("R4 size 12 bits", d, 32'hFFF);
    srcEn = 1'b1;
    f0 = nFired;
    busWrite(A_SIZE, 32'd10);
    busWrite(A_CTRL, 32'h2);
    waitDone("R4");
    repeat (2) @(negedge clk);
    check("R4 word count", nFired - f0, 10);
    busRead(A_OCC, d); check("R4 occupancy", d, 32'd10);
    drainRead(10, "R4 readback data");

    // R5 backpressure with 300 words
    f0 = nFired;
    busWrite(A_SIZE, 32'd300);
    busWrite(A_CTRL, 32'h2);
    for (int i = 0; i < 2000; i++) begin
      busRead(A_OCC, d);
      if (d == 32'd256) break;
    end
    check("R5 occupancy reached full", d, 32'd256);
    repeat (5) @(negedge clk);
    check("R5 stalled count", nFired - f0, 256);
    check("R5 ready low when full", {31'b0, portRdReady}, 32'h0);
    busRead(A_STAT, d); check("R5 still active", d & 32'h1, 32'h0);
    drainRead(100, "R5 data first part");
    waitDone("R5");
    repeat (2) @(negedge clk);
    check("R5 exact total", nFired - f0, 300);
    busRead(A_OCC, d); check("R5 occupancy after", d, 32'd200);
    drainRead(200, "R5 data second part");

    // R6 read from empty queue
    busRead(A_RDATA, d); check("R6 empty read value", d, 32'h0);
    busRead(A_OCC, d);   check("R6 occupancy unchanged", d, 32'h0);

    // R7 zero-size readback
    f0 = nFired;
    busWrite(A_SIZE, 32'd0);
    busWrite(A_CTRL, 32'h2);
    busRead(A_STAT, d); check("R7 done stays high", d & 32'h1, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 no words taken", nFired - f0, 0);
    srcEn = 1'b0;

    // R9 flush both queues
    for (int i = 0; i < 3; i++) pushWord(32'h3000_0000 + i);
    srcEn = 1'b1;
    busWrite(A_SIZE, 32'd4);
    busWrite(A_CTRL, 32'h2);
    waitDone("R9");
    srcEn = 1'b0;
    repeat (2) @(negedge clk);
    busWrite(A_CTRL, 32'h4);
    busRead(A_VAC, d); check("R9 vacancy after flush", d, 32'd1024);
    busRead(A_OCC, d); check("R9 occupancy after flush", d, 32'd0);
    busWrite(A_CTRL, 32'h0);
    expWr.delete();
    expRd.delete();

    // R10 soft reset aborts an active readback
    busWrite(A_SIZE, 32'h123);
    pushWord(32'h4000_0000);
    busWrite(A_CTRL, 32'h2);
    busRead(A_STAT, d); check("R10 active before reset", d & 32'h1, 32'h0);
    busWrite(A_CTRL, 32'h8);
    busRead(A_STAT, d); check("R10 done after reset", d & 32'h1, 32'h1);
    busRead(A_SIZE, d); check("R10 size cleared", d, 32'h0);
    busRead(A_VAC, d);  check("R10 vacancy flushed", d, 32'd1024);
    busWrite(A_CTRL, 32'h0);
    expWr.delete();
    busRead(A_SIZE, d); check("R10 size stays 0", d, 32'h0);

    // R11 status flag mapping
    portFlags = 4'b1010;
    busRead(A_STAT, d); check("R11 status flags", d, 32'h1F | (32'hA << 5));
    portFlags = 4'b0101;
    busRead(A_STAT, d); check("R11 status flags alt", d, 32'h1F | (32'h5 << 5));
    portFlags = 4'b0000;

    // R12 busy port
    portBusy = 1'b1;
    busRead(A_STAT, d); check("R12 busy clears done", d & 32'h1, 32'h0);
    portBusy = 1'b0;
    busRead(A_STAT, d); check("R12 done back", d & 32'h1, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule